// File: doc/BRIEF.md
# Power-Ratio Gain Equalizer for a Four-Way Interleaved Sample Stream

This block sits after offset removal in an interleaved converter and makes the gains of the sub-converters equal. Samples arrive round-robin, with one sample per `in_valid` beat, starting at sub-converter 0. The block sums the squared samples of each sub-converter over a measurement window. When a window closes, it finds for every non-reference sub-converter the square root of the ratio between the reference power and that sub-converter's power. This factor is a gain correction in unsigned Q2.14 form. Each sample is multiplied by the factor of its own sub-converter. The result is rounded and saturated back to the input width.

Sub-converter 0 is the reference and always keeps unity gain. Measurement runs in the background while the stream flows, so conversion never stops. The square root and the division are done by a sequential solver with five states:
- `ST_IDLE`: waits for the end of a window and takes a snapshot of the four power sums.
- `ST_PREP`: loads the divider for the selected sub-converter. It leaves early for a power of zero or a saturated ratio.
- `ST_DIV`: restoring division, one quotient bit per clock.
- `ST_ROOT`: digit-by-digit square root, one result bit per clock.
- `ST_WRITE`: commits the factor and then goes to `ST_PREP` for the next sub-converter, or to `ST_IDLE` after the last one.

The transitions are named as follows:
- window-end: `ST_IDLE` to `ST_PREP`
- skip: `ST_PREP` to `ST_WRITE`
- divide: `ST_PREP` to `ST_DIV`
- quotient-done: `ST_DIV` to `ST_ROOT`
- root-done: `ST_ROOT` to `ST_WRITE`
- next-channel: `ST_WRITE` to `ST_PREP`
- all-done: `ST_WRITE` to `ST_IDLE`

Top module: `gain_ratio_eq`

## Requirements
- R1: After reset `out_valid` is 0, and every 16-bit field of `gain_o` is 0x4000 (1.0 in unsigned Q2.14). Field c sits at bits [16c+15:16c].
- R2: The first valid sample after reset belongs to sub-converter 0. Valid samples then cycle through 0,1,2,3. Cycles with `in_valid` low do not advance the channel.
- R3: `out_valid` is `in_valid` delayed by one clock. `out_data` is floor((x*g + 8192)/16384), where x is the signed input sample and g is the current factor of that sample's sub-converter.
- R4: Samples of sub-converter 0 pass through unchanged, because its factor is fixed at 0x4000.
- R5: Power Pc is the sum of x*x over 2^WIN_LOG2 valid samples of sub-converter c (64 by default). A window ends with the last such sample of sub-converter 3. Factors change only after that sample, and all of them are final within 300 clocks of it.
- R6: For sub-converter i ≥ 1 with 0 < 16*Pi and P0 < 16*Pi, the new factor is floor(sqrt(floor(P0*2^28/Pi))).
- R7: When P0 ≥ 16*Pi with Pi > 0, the factor of sub-converter i saturates to 0xFFFF.
- R8: When Pi is 0, the factor of sub-converter i keeps its previous value.
- R9: A scaled result above 2^(DATA_W-1)-1 gives 2047, and one below -2^(DATA_W-1) gives -2048 (DATA_W = 12). Zero input gives zero output.
- R10: Outside an update sequence the factors stay constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Offset-free signed interleaved sample |
| out_valid | output | 1 | Corrected sample strobe |
| out_data | output | DATA_W | Gain-corrected signed sample |
| gain_o | output | 16*NUM_CH | Q2.14 factors, sub-converter c at bits [16c+15:16c] |

## Verification
The conditions that are hardest to reach from the ports are the solver's two early exits: a sub-converter with no power at all, and one whose power is more than sixteen times below the reference. Each needs a whole window built for it, and in that window the power ratio never appears directly at any port. The stimulus therefore drives one window with sub-converter 2 held at zero and sub-converter 3 held at a tiny amplitude. The following window drives full-scale samples on sub-converter 3, so that its saturated factor pushes the multiplier into output clipping. Random amplitudes for each sub-converter and random idle gaps surround these directed windows, which exercises the channel tracking through valid gaps.

// File: rtl/gre_pkg.sv
package gre_pkg;
    localparam int GAIN_W    = 16;
    localparam int GAIN_FRAC = 14;
    localparam int GAIN_INT  = GAIN_W - GAIN_FRAC;
    localparam logic [GAIN_W-1:0] GAIN_UNITY = 16'h4000;
    localparam logic [GAIN_W-1:0] GAIN_MAX   = 16'hFFFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_DIV,
        ST_ROOT,
        ST_WRITE
    } solve_state_e;
endpackage

// File: rtl/gre_power_acc.sv
// Per-channel sum-of-squares accumulator with round-robin channel tracking.
module gre_power_acc #(
    parameter int NUM_CH   = 4,
    parameter int DATA_W   = 12,
    parameter int WIN_LOG2 = 6,
    parameter int ACC_W    = 2 * DATA_W + WIN_LOG2,
    parameter int CH_W     = $clog2(NUM_CH)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  logic signed [DATA_W-1:0]            in_data,
    output logic [CH_W-1:0]                     ch_idx,
    output logic                                win_last,
    output logic [NUM_CH-1:0][ACC_W-1:0]        pwr
);
    logic [CH_W-1:0]               ch_q;
    logic [WIN_LOG2-1:0]           frm_q;
    logic [NUM_CH-1:0][ACC_W-1:0]  acc_q;
    logic signed [2*DATA_W-1:0]    sq_s;
    logic [ACC_W-1:0]              sq_u;

    assign sq_s     = in_data * in_data;
    assign sq_u     = {{WIN_LOG2{1'b0}}, sq_s};
    assign ch_idx   = ch_q;
    assign win_last = in_valid && (ch_q == CH_W'(NUM_CH - 1)) && (frm_q == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q  <= '0;
            frm_q <= '0;
        end else if (in_valid) begin
            if (ch_q == CH_W'(NUM_CH - 1)) begin
                ch_q  <= '0;
                frm_q <= frm_q + 1'b1;
            end else begin
                ch_q <= ch_q + 1'b1;
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        // power including the sample presented this cycle
        assign pwr[c] = acc_q[c] + ((in_valid && ch_q == CH_W'(c)) ? sq_u : '0);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q[c] <= '0;
            end else if (win_last) begin
                acc_q[c] <= '0;
            end else if (in_valid && ch_q == CH_W'(c)) begin
                acc_q[c] <= pwr[c];
            end
        end
    end
endmodule

// File: rtl/gre_solver.sv
// Sequential solver: factor_i = sqrt(P0 / Pi) in Q2.14 via restoring divide and bitwise root.
module gre_solver
    import gre_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ACC_W  = 30,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    input  logic [NUM_CH-1:0][ACC_W-1:0]        pwr,
    output logic [NUM_CH-1:0][GAIN_W-1:0]       gain,
    output logic                                busy
);
    localparam int DIV_W      = ACC_W + 2 * GAIN_FRAC;
    localparam int RATIO_W    = 2 * GAIN_W;
    localparam int ROOT_STEPS = GAIN_W;
    localparam int SAT_SH     = 2 * GAIN_INT;
    localparam int CNT_W      = $clog2(DIV_W + 1);

    solve_state_e state_q, state_d;

    logic [NUM_CH-1:0][ACC_W-1:0]  snap_q;
    logic [NUM_CH-1:0][GAIN_W-1:0] gain_q;
    logic [CH_W-1:0]               sel_q;
    logic [DIV_W-1:0]              dq_q;
    logic [ACC_W-1:0]              rem_q;
    logic [ACC_W-1:0]              den_q;
    logic [CNT_W-1:0]              cnt_q;
    logic [RATIO_W-1:0]            op_q, res_q, one_q;
    logic [GAIN_W-1:0]             fac_q;

    // early-exit decisions for the selected channel
    logic [ACC_W-1:0]        p_ref, p_sel;
    logic                    den_zero, ratio_sat;
    assign p_ref     = snap_q[0];
    assign p_sel     = snap_q[sel_q];
    assign den_zero  = (p_sel == '0);
    assign ratio_sat = ({{SAT_SH{1'b0}}, p_ref} >= {p_sel, {SAT_SH{1'b0}}});

    // one restoring division step
    logic [ACC_W:0]          rem_sh;
    logic                    div_ge;
    logic [ACC_W:0]          rem_sub;
    logic [ACC_W-1:0]        rem_nx;
    logic [DIV_W-1:0]        dq_nx;
    assign rem_sh  = {rem_q, dq_q[DIV_W-1]};
    assign div_ge  = (rem_sh >= {1'b0, den_q});
    assign rem_sub = rem_sh - {1'b0, den_q};
    assign rem_nx  = div_ge ? rem_sub[ACC_W-1:0] : rem_sh[ACC_W-1:0];
    assign dq_nx   = {dq_q[DIV_W-2:0], div_ge};

    // one square-root step
    logic [RATIO_W-1:0]      trial, op_nx, res_nx;
    logic                    root_ge;
    assign trial   = res_q + one_q;
    assign root_ge = (op_q >= trial);
    assign op_nx   = root_ge ? (op_q - trial) : op_q;
    assign res_nx  = root_ge ? ((res_q >> 1) + one_q) : (res_q >> 1);

    assign gain = gain_q;
    assign busy = (state_q != ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_PREP;
            ST_PREP:  state_d = (den_zero || ratio_sat) ? ST_WRITE : ST_DIV;
            ST_DIV:   if (cnt_q == '0) state_d = ST_ROOT;
            ST_ROOT:  if (cnt_q == '0) state_d = ST_WRITE;
            ST_WRITE: state_d = (sel_q == CH_W'(NUM_CH - 1)) ? ST_IDLE : ST_PREP;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath and factor registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
            gain_q <= {NUM_CH{GAIN_UNITY}};
            sel_q  <= '0;
            dq_q   <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            op_q   <= '0;
            res_q  <= '0;
            one_q  <= '0;
            fac_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        snap_q <= pwr;
                        sel_q  <= CH_W'(1);
                    end
                end
                ST_PREP: begin
                    den_q <= p_sel;
                    dq_q  <= {p_ref, {(2 * GAIN_FRAC){1'b0}}};
                    rem_q <= '0;
                    cnt_q <= CNT_W'(DIV_W - 1);
                    if (den_zero)       fac_q <= gain_q[sel_q];
                    else if (ratio_sat) fac_q <= GAIN_MAX;
                end
                ST_DIV: begin
                    dq_q  <= dq_nx;
                    rem_q <= rem_nx;
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == '0) begin
                        op_q  <= dq_nx[RATIO_W-1:0];
                        res_q <= '0;
                        one_q <= RATIO_W'(1) << (RATIO_W - 2);
                        cnt_q <= CNT_W'(ROOT_STEPS - 1);
                    end
                end
                ST_ROOT: begin
                    op_q  <= op_nx;
                    res_q <= res_nx;
                    one_q <= one_q >> 2;
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == '0) fac_q <= res_nx[GAIN_W-1:0];
                end
                ST_WRITE: begin
                    gain_q[sel_q] <= fac_q;
                    sel_q         <= sel_q + 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gre_scale.sv
// Multiplies a sample by its Q2.14 factor, rounds half up, saturates to DATA_W.
module gre_scale
    import gre_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    input  logic [GAIN_W-1:0]        gain,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);
    localparam int PROD_W = DATA_W + GAIN_W + 1;
    localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (GAIN_FRAC - 1);
    localparam logic signed [PROD_W-1:0] MAXV = PROD_W'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] MINV = -(PROD_W'(1) <<< (DATA_W - 1));

    logic signed [PROD_W-1:0] prod, rnd, shr;
    logic signed [DATA_W-1:0] sat;

    assign prod = in_data * $signed({1'b0, gain});
    assign rnd  = prod + HALF;
    assign shr  = rnd >>> GAIN_FRAC;

    always_comb begin
        if (shr > MAXV)      sat = MAXV[DATA_W-1:0];
        else if (shr < MINV) sat = MINV[DATA_W-1:0];
        else                 sat = shr[DATA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= sat;
        end
    end
endmodule

// File: rtl/gain_ratio_eq.sv
module gain_ratio_eq
    import gre_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int DATA_W   = 12,
    parameter int WIN_LOG2 = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic signed [DATA_W-1:0]      in_data,
    output logic                          out_valid,
    output logic signed [DATA_W-1:0]      out_data,
    output logic [GAIN_W*NUM_CH-1:0]      gain_o
);
    localparam int ACC_W = 2 * DATA_W + WIN_LOG2;
    localparam int CH_W  = $clog2(NUM_CH);

    logic [CH_W-1:0]                 ch_idx;
    logic                            win_last;
    logic [NUM_CH-1:0][ACC_W-1:0]    pwr;
    logic [NUM_CH-1:0][GAIN_W-1:0]   gain_arr;
    logic                            solve_busy;

    gre_power_acc #(
        .NUM_CH(NUM_CH), .DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2),
        .ACC_W(ACC_W), .CH_W(CH_W)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .ch_idx(ch_idx), .win_last(win_last), .pwr(pwr)
    );

    gre_solver #(
        .NUM_CH(NUM_CH), .ACC_W(ACC_W), .CH_W(CH_W)
    ) u_solver (
        .clk(clk), .rst_n(rst_n), .start(win_last), .pwr(pwr),
        .gain(gain_arr), .busy(solve_busy)
    );

    gre_scale #(
        .DATA_W(DATA_W)
    ) u_scale (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .gain(gain_arr[ch_idx]), .out_valid(out_valid), .out_data(out_data)
    );

    assign gain_o = gain_arr;
endmodule

// File: rtl/gain_ratio_eq_chk.sv
module gain_ratio_eq_chk #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 12
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic signed [DATA_W-1:0]  in_data,
    input logic                      out_valid,
    input logic signed [DATA_W-1:0]  out_data,
    input logic [16*NUM_CH-1:0]      gain_o,
    input logic                      solve_busy,
    input logic                      win_last
);
    localparam int CW = $clog2(NUM_CH);
    logic [CW-1:0] chk_ch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        chk_ch <= '0;
        else if (in_valid) chk_ch <= (chk_ch == CW'(NUM_CH - 1)) ? '0 : chk_ch + 1'b1;
    end

    a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r3_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r3_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_data[DATA_W-1]) |=> !out_data[DATA_W-1]);
    a_r4_ref_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chk_ch == '0) |=> (out_data == $past(in_data)));
    a_r9_zero_in: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data == '0) |=> (out_data == '0));
    a_r10_gain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !solve_busy |=> $stable(gain_o));
    a_r5_start_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(solve_busy) |-> $past(win_last));
endmodule

bind gain_ratio_eq gain_ratio_eq_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .gain_o(gain_o),
    .solve_busy(solve_busy), .win_last(win_last)
);

// File: tb/gain_ratio_eq_tb.sv
module gain_ratio_eq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 4;
    localparam int DW   = 12;
    localparam int WINL = 6;
    localparam int PER_CH = 1 << WINL;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic signed [DW-1:0]  in_data = '0;
    logic                  out_valid;
    logic signed [DW-1:0]  out_data;
    logic [16*NCH-1:0]     gain_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    longint unsigned sums [NCH];
    int unsigned     gm   [NCH];
    int              bch = 0;
    int              amp  [NCH];

    gain_ratio_eq #(.NUM_CH(NCH), .DATA_W(DW), .WIN_LOG2(WINL)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .gain_o(gain_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic longint unsigned isqrt(longint unsigned v);
        longint unsigned lo = 0, hi = 65536, mid;
        while (lo < hi) begin
            mid = (lo + hi + 1) / 2;
            if (mid * mid <= v) lo = mid; else hi = mid - 1;
        end
        return lo;
    endfunction

    function automatic int scale(int x, int unsigned g);
        longint p = longint'(x) * longint'(g);
        longint r = (p + 8192) >>> 14;
        if (r > 2047) r = 2047;
        if (r < -2048) r = -2048;
        return int'(r);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int x);
        int e;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = DW'(x);
        e = scale(x, gm[bch]);
        sums[bch] += longint'(x * x);
        bch = (bch + 1) % NCH;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R3 out_valid", out_valid, 1);
        check(out_data == DW'(e), (e == 2047 || e == -2048) ? "R9 saturation" : "R2/R3 scaled sample",
              out_data, e);
        repeat ($urandom_range(0, 2)) @(negedge clk);
    endtask

    // one window of 2^WINL samples per channel; mode selects directed values
    task automatic run_window(input int mode);
        for (int f = 0; f < PER_CH; f++) begin
            for (int c = 0; c < NCH; c++) begin
                int x;
                if (amp[c] == 0) x = 0;
                else x = int'($urandom_range(0, 2 * amp[c])) - amp[c];
                if (mode == 1 && c == 0 && f == 3) x = -2048;
                if (mode == 2 && c == 3) x = (f % 2 == 0) ? 2047 : -2047;
                if (mode == 2 && c == 1 && f == 5) x = 0;
                send(x);
            end
            check(gain_o == {16'(gm[3]), 16'(gm[2]), 16'(gm[1]), 16'(gm[0])},
                  "R10 factors steady in window", longint'(gain_o[31:16]), gm[1]);
        end
    endtask

    task automatic update_and_check();
        repeat (300) @(negedge clk);
        for (int c = 1; c < NCH; c++) begin
            string req;
            if (sums[c] == 0) begin
                req = "R8 zero power holds";
            end else if (sums[0] >= 16 * sums[c]) begin
                gm[c] = 16'hFFFF;
                req = "R7 ratio saturates";
            end else begin
                gm[c] = int'(isqrt((sums[0] << 28) / sums[c]));
                req = "R5/R6 sqrt ratio";
            end
            check(gain_o[c*16 +: 16] == 16'(gm[c]), req, gain_o[c*16 +: 16], gm[c]);
        end
        check(gain_o[15:0] == 16'h4000, "R4 reference unity", gain_o[15:0], 16'h4000);
        for (int c = 0; c < NCH; c++) sums[c] = 0;
    endtask

    initial begin
        void'($urandom(32'd20517));
        for (int c = 0; c < NCH; c++) begin sums[c] = 0; gm[c] = 16'h4000; end
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
        check(gain_o == {NCH{16'h4000}}, "R1 reset factors", gain_o[31:16], 16'h4000);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R3 idle no output", out_valid, 0);

        // window 1: random amplitudes, unity factors
        amp[0] = 1500; amp[1] = 1200; amp[2] = 1800; amp[3] = 900;
        run_window(0);
        update_and_check();

        // window 2: silent channel 2, tiny channel 3
        amp[0] = 2000; amp[1] = 1700; amp[2] = 0; amp[3] = 60;
        run_window(1);
        update_and_check();

        // window 3: full scale on channel 3 against its saturated factor
        amp[0] = 1000; amp[1] = 1100; amp[2] = 900; amp[3] = 2047;
        run_window(2);
        update_and_check();

        // window 4: random again
        amp[0] = 700; amp[1] = 800; amp[2] = 650; amp[3] = 720;
        run_window(0);
        update_and_check();

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule